// File: doc/BRIEF.md
# Cartridge ROM and Save-RAM Address Mapper

This block sits between a processor's 24-bit bank:offset address bus and the memories on a game cartridge. For every address it decides whether the program ROM, the battery-backed save RAM or neither should respond. It produces the matching chip enable and a linear byte address into the selected memory.

Two board wiring schemes are supported and chosen by a static mode pin. The narrow scheme folds 32 KB of ROM into the upper half of each bank. The wide scheme gives ROM whole 64 KB banks in two bank ranges. Each scheme places the save-RAM window in a different region.

Mirroring is done only by dropping high address bits. A small ROM or save RAM therefore repeats across its window without any extra storage. ROM size and save-RAM size come from two small power-of-two codes. All outputs are registered, with one cycle of latency.

Top module: `cart_mapper`

## Requirements
- R1: With wideMode=0, an access with offset $8000–$FFFF in any bank except $7E and $7F enables ROM at address (bank mod $80)×$8000 + (offset−$8000). For example, $03:8000 gives $018000.
- R2: Banks $7E and $7F never enable ROM in either mode. In narrow mode, banks $FE and $FF still do.
- R3: With wideMode=1, banks $C0–$FF enable ROM at (bank−$C0)×$10000 + offset, and banks $40–$7D enable ROM at (bank−$40)×$10000 + offset, for every offset.
- R4: The ROM address is the unfolded address modulo the ROM size, where the size is $8000 shifted left by romSizeCode. Codes above 7 are treated as 7 (4 MB).
- R5: With wideMode=0, banks $70–$7D at offsets $0000–$7FFF enable save RAM at address offset modulo the save-RAM size.
- R6: With wideMode=1, banks $20–$3F and $A0–$BF at offsets $6000–$7FFF enable save RAM. The address is ((bank mod $20)×$2000 + offset−$6000) modulo the save-RAM size.
- R7: sramSizeCode 0 means no save RAM, and sramEn stays low. A code k from 1 to 5 means 1 KB shifted left by k (2 KB to 32 KB). Codes 6 and 7 are treated as 5.
- R8: With cartSel low, neither enable is asserted.
- R9: romEn and sramEn are never high together.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. Reset (rstN low) clears all outputs to zero.
- R11: Whenever an enable is low, its address output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cartSel | input | 1 | Cartridge region select, active high |
| wideMode | input | 1 | 0: 32 KB bank folding, 1: 64 KB bank folding |
| bank | input | 8 | Bank byte of the processor address |
| offset | input | 16 | Offset within the bank |
| romSizeCode | input | 4 | ROM size: $8000 << code bytes |
| sramSizeCode | input | 3 | Save-RAM size: 0 none, else 1 KB << code |
| romEn | output | 1 | ROM chip enable, active high |
| romAddr | output | 22 | ROM byte address |
| sramEn | output | 1 | Save-RAM chip enable, active high |
| sramAddr | output | 15 | Save-RAM byte address |

## Verification
Both modes are swept over all 256 banks. Each bank is tried with a set of offsets chosen on the region borders: $0000, $5FFF, $6000, $7FFF, $8000 and $FFFF, plus interior points. This separates the lower-half and upper-half decode, the 8 KB save window of the wide mode and the $7E/$7F gap. The sweep is repeated with small and full ROM and save-RAM size codes, so that a wrong mask is told apart from a wrong fold. A pass with cartSel low and a latency probe between clock edges distinguish gating and register timing from the address arithmetic.

// File: rtl/cart_map_pkg.sv
package cart_map_pkg;

  // Strobes from the decode control to the address datapath.
  typedef struct packed {
    logic romSel;    // address falls in a ROM region
    logic sramSel;   // address falls in an enabled save-RAM window
    logic wideFold;  // 64 KB bank folding in use
  } map_strobe_t;

endpackage

// File: rtl/cart_map_ctrl.sv
module cart_map_ctrl
  import cart_map_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int OFF_W   = 16,
  parameter int SCODE_W = 3
) (
  input  logic               cartSel,
  input  logic               wideMode,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFF_W-1:0]   offset,
  input  logic [SCODE_W-1:0] sramSizeCode,
  output map_strobe_t        strobes
);

  // Bank-range constants (work RAM pair, save windows).
  localparam logic [BANK_W-2:0] WRAM_PAIR    = 7'h3F;  // banks $7E/$7F
  localparam logic [3:0]        NSAVE_HI_NIB = 4'h7;   // banks $7x
  localparam logic [3:0]        NSAVE_LAST   = 4'hD;   // up to $7D
  localparam logic [2:0]        WSAVE_SLICE  = 3'b011; // offsets $6000-$7FFF

  logic inWram;
  logic narrowRom, wideRom, narrowSram, wideSram;
  logic sramPresent;

  always_comb begin
    inWram      = (bank[BANK_W-1:1] == WRAM_PAIR);
    sramPresent = (sramSizeCode != '0);

    // 32 KB folding: upper half of every bank except the work-RAM pair.
    narrowRom  = offset[OFF_W-1] && !inWram;
    // 64 KB folding: $C0-$FF outright, $40-$7D outright.
    wideRom    = (bank[BANK_W-1:BANK_W-2] == 2'b11) ||
                 ((bank[BANK_W-1:BANK_W-2] == 2'b01) && !inWram);

    narrowSram = (bank[BANK_W-1:BANK_W-4] == NSAVE_HI_NIB) &&
                 (bank[3:0] <= NSAVE_LAST) && !offset[OFF_W-1];
    // $20-$3F and $A0-$BF share bank bits [6:5] = 01.
    wideSram   = (bank[BANK_W-2:BANK_W-3] == 2'b01) &&
                 (offset[OFF_W-1:OFF_W-3] == WSAVE_SLICE);

    strobes.wideFold = wideMode;
    strobes.romSel   = cartSel && (wideMode ? wideRom : narrowRom);
    strobes.sramSel  = cartSel && sramPresent &&
                       (wideMode ? wideSram : narrowSram);
  end

endmodule

// File: rtl/cart_map_dp.sv
module cart_map_dp
  import cart_map_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int OFF_W   = 16,
  parameter int RCODE_W = 4,
  parameter int SCODE_W = 3,
  parameter int ROM_AW  = 22,
  parameter int SRAM_AW = 15,
  parameter int SRAM_LG_BASE = 10  // code k -> 2^(SRAM_LG_BASE+k) bytes
) (
  input  logic               clk,
  input  logic               rstN,
  input  map_strobe_t        strobes,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFF_W-1:0]   offset,
  input  logic [RCODE_W-1:0] romSizeCode,
  input  logic [SCODE_W-1:0] sramSizeCode,
  output logic               romEn,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               sramEn,
  output logic [SRAM_AW-1:0] sramAddr
);

  localparam int ROM_LG_MIN   = OFF_W - 1;            // 32 KB smallest ROM
  localparam int ROM_CODE_MAX = ROM_AW - ROM_LG_MIN;
  localparam int SRAM_CODE_MAX = SRAM_AW - SRAM_LG_BASE;
  localparam int WSAVE_LOW_W  = OFF_W - 3;            // 8 KB save slice

  logic [ROM_AW-1:0]  narrowRaw, wideRaw, romRaw, romMask;
  logic [SRAM_AW-1:0] sramNarrowRaw, sramWideRaw, sramRaw, sramMask;
  int unsigned romLg, sramLg;

  always_comb begin
    narrowRaw = ROM_AW'({bank[BANK_W-2:0], offset[OFF_W-2:0]});
    wideRaw   = ROM_AW'({bank[BANK_W-3:0], offset});
    romRaw    = strobes.wideFold ? wideRaw : narrowRaw;

    sramNarrowRaw = SRAM_AW'(offset[OFF_W-2:0]);
    sramWideRaw   = SRAM_AW'({bank[4:0], offset[WSAVE_LOW_W-1:0]});
    sramRaw       = strobes.wideFold ? sramWideRaw : sramNarrowRaw;

    romLg  = ROM_LG_MIN + ((int'(romSizeCode) > ROM_CODE_MAX) ?
                           ROM_CODE_MAX : int'(romSizeCode));
    sramLg = SRAM_LG_BASE + ((int'(sramSizeCode) > SRAM_CODE_MAX) ?
                             SRAM_CODE_MAX : int'(sramSizeCode));
  end

  // Size masks: one comparator per address bit.
  for (genvar i = 0; i < ROM_AW; i++) begin : g_romMask
    assign romMask[i] = (i < romLg);
  end
  for (genvar j = 0; j < SRAM_AW; j++) begin : g_sramMask
    assign sramMask[j] = (j < sramLg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      romEn    <= 1'b0;
      romAddr  <= '0;
      sramEn   <= 1'b0;
      sramAddr <= '0;
    end else begin
      romEn    <= strobes.romSel;
      romAddr  <= strobes.romSel  ? (romRaw & romMask)   : '0;
      sramEn   <= strobes.sramSel;
      sramAddr <= strobes.sramSel ? (sramRaw & sramMask) : '0;
    end
  end

endmodule

// File: rtl/cart_mapper.sv
module cart_mapper
  import cart_map_pkg::*;
#(
  parameter int BANK_W  = 8,
  parameter int OFF_W   = 16,
  parameter int RCODE_W = 4,
  parameter int SCODE_W = 3,
  parameter int ROM_AW  = 22,
  parameter int SRAM_AW = 15
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cartSel,
  input  logic               wideMode,
  input  logic [BANK_W-1:0]  bank,
  input  logic [OFF_W-1:0]   offset,
  input  logic [RCODE_W-1:0] romSizeCode,
  input  logic [SCODE_W-1:0] sramSizeCode,
  output logic               romEn,
  output logic [ROM_AW-1:0]  romAddr,
  output logic               sramEn,
  output logic [SRAM_AW-1:0] sramAddr
);

  map_strobe_t strobes;

  cart_map_ctrl #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .SCODE_W(SCODE_W)
  ) u_ctrl (
    .cartSel(cartSel), .wideMode(wideMode), .bank(bank),
    .offset(offset), .sramSizeCode(sramSizeCode), .strobes(strobes)
  );

  cart_map_dp #(
    .BANK_W(BANK_W), .OFF_W(OFF_W), .RCODE_W(RCODE_W),
    .SCODE_W(SCODE_W), .ROM_AW(ROM_AW), .SRAM_AW(SRAM_AW),
    .SRAM_LG_BASE(10)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .bank(bank),
    .offset(offset), .romSizeCode(romSizeCode),
    .sramSizeCode(sramSizeCode), .romEn(romEn), .romAddr(romAddr),
    .sramEn(sramEn), .sramAddr(sramAddr)
  );

endmodule

// File: rtl/cart_mapper_chk.sv
module cart_mapper_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cartSel,
  input logic        wideMode,
  input logic [7:0]  bank,
  input logic [15:0] offset,
  input logic [3:0]  romSizeCode,
  input logic [2:0]  sramSizeCode,
  input logic        romEn,
  input logic [21:0] romAddr,
  input logic        sramEn,
  input logic [14:0] sramAddr
);

  p_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    !(romEn && sramEn));

  p_nosel_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(cartSel)) |-> (!romEn && !sramEn));

  p_nosram_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(sramSizeCode) == 3'd0)) |-> !sramEn);

  p_wram_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(bank[7:1]) == 7'h3F)) |-> !romEn);

  p_rom_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !romEn |-> (romAddr == '0));

  p_sram_idle_r11: assert property (@(posedge clk) disable iff (!rstN)
    !sramEn |-> (sramAddr == '0));

  p_sram_2k_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(sramSizeCode) == 3'd1)) |-> (sramAddr[14:11] == 4'd0));

  p_rom_32k_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ($past(romSizeCode) == 4'd0)) |-> (romAddr[21:15] == 7'd0));

endmodule

bind cart_mapper cart_mapper_chk u_chk (.*);

// File: tb/sim_cart_mapper.sv
module sim_cart_mapper;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cartSel = 1'b0;
  logic        wideMode = 1'b0;
  logic [7:0]  bank = '0;
  logic [15:0] offset = '0;
  logic [3:0]  romSizeCode = '0;
  logic [2:0]  sramSizeCode = '0;
  logic        romEn, sramEn;
  logic [21:0] romAddr;
  logic [14:0] sramAddr;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  cart_mapper u0 (
    .clk(clk), .rstN(rstN), .cartSel(cartSel), .wideMode(wideMode),
    .bank(bank), .offset(offset), .romSizeCode(romSizeCode),
    .sramSizeCode(sramSizeCode), .romEn(romEn), .romAddr(romAddr),
    .sramEn(sramEn), .sramAddr(sramAddr)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (mode %0d bank %0h off %0h rc %0d sc %0d)",
               tag, act, exp, wideMode, bank, offset, romSizeCode, sramSizeCode);
    end
  endtask

  // Reference model, written from the requirements.
  task automatic model(input bit w, input bit sel, input int bk, input int off,
                       input int rc, input int sc,
                       output bit eR, output int eRA, output bit eS, output int eSA);
    int romSize, sramSize, raw, sraw;
    bit rHit, sHit;
    romSize  = 32768 << ((rc > 7) ? 7 : rc);
    sramSize = (sc == 0) ? 0 : (1024 << ((sc > 5) ? 5 : sc));
    if (!w) begin
      rHit = (off >= 32'h8000) && !(bk == 'h7E || bk == 'h7F);
      raw  = (bk % 128) * 32'h8000 + (off - 32'h8000);
      sHit = (bk >= 'h70) && (bk <= 'h7D) && (off < 32'h8000);
      sraw = off;
    end else begin
      rHit = (bk >= 'hC0) || ((bk >= 'h40) && (bk <= 'h7D));
      raw  = (bk >= 'hC0) ? (bk - 'hC0) * 32'h10000 + off
                          : (bk - 'h40) * 32'h10000 + off;
      sHit = (((bk >= 'h20) && (bk <= 'h3F)) || ((bk >= 'hA0) && (bk <= 'hBF))) &&
             (off >= 'h6000) && (off < 'h8000);
      sraw = (bk % 32) * 32'h2000 + (off - 'h6000);
    end
    eR  = sel && rHit;
    eRA = eR ? (raw % romSize) : 0;
    eS  = sel && sHit && (sc != 0);
    eSA = eS ? (sraw % sramSize) : 0;
  endtask

  task automatic vec(input bit w, input bit sel, input int bk, input int off,
                     input int rc, input int sc, input string tag);
    bit eR, eS;
    int eRA, eSA;
    @(negedge clk);
    wideMode = w; cartSel = sel; bank = 8'(bk); offset = 16'(off);
    romSizeCode = 4'(rc); sramSizeCode = 3'(sc);
    model(w, sel, bk, off, rc, sc, eR, eRA, eS, eSA);
    @(posedge clk); #1;
    check({tag, " romEn"},    romEn,    eR);
    check({tag, " romAddr"},  romAddr,  eRA);
    check({tag, " sramEn"},   sramEn,   eS);
    check({tag, " sramAddr"}, sramAddr, eSA);
    check("R9 exclusive", romEn & sramEn, 0);
  endtask

  initial begin
    #(4 * 190000);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int offs[8] = '{'h0000, 'h1234, 'h5FFF, 'h6000, 'h7FFF, 'h8000, 'h9C40, 'hFFFF};
    // R10: reset state
    cartSel = 1'b1; offset = 16'h8000;
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset romEn", romEn, 0);
    check("R10 reset sramEn", sramEn, 0);
    check("R10 reset romAddr", romAddr, 0);
    @(negedge clk); rstN = 1'b1;

    // Directed points
    vec(0, 1, 'h03, 'h8000, 7, 5, "R1 03:8000");
    check("R1 03:8000 value", romAddr, 'h018000);
    vec(0, 1, 'h7E, 'h8000, 7, 5, "R2 bank7E");
    vec(0, 1, 'hFF, 'hFFFF, 7, 5, "R2 bankFF");
    check("R2 bankFF value", romAddr, 'h3FFFFF);
    vec(1, 1, 'hC0, 'h1234, 7, 5, "R3 C0");
    vec(1, 1, 'h7F, 'h0000, 7, 5, "R3 R2 7F wide");
    vec(0, 1, 'h13, 'h9C40, 2, 5, "R4 mirror");
    vec(0, 1, 'h7D, 'h7FFF, 7, 1, "R5 R7 2K");
    vec(1, 1, 'hBF, 'h7FFF, 7, 5, "R6 BF");
    for (int sc = 0; sc < 8; sc++) vec(1, 1, 'h3F, 'h7FFF, 7, sc, "R7 code sweep");

    // R10 latency: output holds until the next edge
    vec(0, 1, 'h05, 'h8001, 7, 5, "R10 pre");
    @(negedge clk); cartSel = 1'b0; #1;
    check("R10 hold before edge", romEn, 1);
    @(posedge clk); #1;
    check("R10 R8 after edge", romEn, 0);

    // Sweeps
    for (int w = 0; w < 2; w++)
      for (int bk = 0; bk < 256; bk++)
        for (int k = 0; k < 8; k++) begin
          vec(w[0], 1, bk, offs[k], 7, 5, w ? "R3 R6 sweep" : "R1 R5 sweep");
          vec(w[0], 1, bk, offs[k], bk % 3, 1 + (bk % 3), "R4 R7 small sweep");
        end
    for (int bk = 0; bk < 256; bk += 3)
      for (int w = 0; w < 2; w++) vec(w[0], 0, bk, 'h7000 + bk * 64, 7, 5, "R8 deselect");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule